// File: doc/BRIEF.md
# Cascadable Pixel Readout Sequencer

This block is the digital control for one section of a linear image sensor that has 128 pixels. A single start pulse, captured on a rising clock edge, loads a one-hot token into a shift chain. On each later clock the token moves one stage. The stage that holds the token drives a one-cycle select strobe, which routes that pixel's stored sample onto the shared output. One cycle later a reset strobe for the same pixel clears its integrator, and the pixel's next integration period begins.

While a pixel is selected, an output-enable is high and a binary pixel index is valid. The output-enable stands for the analog output being driven. When it is low, the analog output is in high impedance. When the token leaves the last stage, a one-cycle end-of-scan pulse is produced. This pulse has the same timing as the start input, so it can drive the start input of a following identical section directly. Several sections chained this way read out as one continuous array.

Top module: `pixSeqTop`

## Requirements
- R1: While the asynchronous active-low reset is asserted, and after it is released with the start input low, `pixSel`, `pixRst`, `outEn` and `endScan` are all zero.
- R2: When the section is idle and `startIn` is 1 at a rising edge, in the cycle after that edge `pixSel` bit 0 is the only bit set, `outEn` is 1 and `pixIdx` is 0.
- R3: On each following rising edge the select advances by one bit position. Pixels are selected in the order bit 0 to bit 127, each for exactly one cycle, and at most one `pixSel` bit is set at any time.
- R4: `pixRst` bit n is high for exactly the one cycle that follows the cycle in which `pixSel` bit n was high, so the select and reset of the same pixel never overlap.
- R5: `outEn` is high for exactly 128 consecutive cycles per scan, exactly the cycles in which some `pixSel` bit is high, and is low at all other times.
- R6: While `outEn` is high, `pixIdx` equals the position of the set `pixSel` bit (0 to 127).
- R7: `endScan` rises after the 129th rising edge, counting the edge that captured the start as the first. It stays high for exactly one cycle, the same cycle in which `pixRst` bit 127 is high.
- R8: A 1 on `startIn` at any rising edge while a scan is in progress is ignored: it has no effect on the select sequence, and the section does not start a new scan. This includes the edge that ends the scan.
- R9: At the rising edge at which `endScan` is high, the section is already idle and accepts a start. When `endScan` is fed back to `startIn`, the scans follow each other with a period of 129 cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock shared by all chained sections |
| rst_n | input | 1 | Asynchronous active-low reset |
| startIn | input | 1 | Serial start; a 1 captured while idle begins a scan |
| pixSel | output | 128 | One-hot select strobe, bit n routes pixel n to the output |
| pixRst | output | 128 | One-hot reset strobe, bit n clears pixel n's integrator |
| pixIdx | output | 7 | Index of the selected pixel, valid while outEn is high |
| outEn | output | 1 | High while the shared output is driven, low for high impedance |
| endScan | output | 1 | One-cycle end-of-scan pulse, drives the next section's start |

## Verification
A lost or duplicated token is visible at the ports in the next cycle. A select bit would be missing or a second one would be set, and the index would stop matching the select. A token that is dropped early cuts the output-enable window below 128 cycles and brings the end-of-scan pulse too soon, which a chained section sees at once. A busy check that is wrong shows up as a second token, or as a select sequence that restarts, in the cycle after a start arrives in the middle of a scan. A wrong reset delay misplaces a `pixRst` bit against the select sequence within one cycle. The bench follows a separate behavioural pixel position and compares every output on every clock. That covers single pulses, starts sent in the middle of a scan and in its last cycle, a start held high, and end-of-scan fed back to the start input.

// File: rtl/pixSeqPkg.sv
package pixSeqPkg;
  // Strobes passed from the token chain control to the datapath
  typedef struct packed {
    logic take;    // start accepted at the coming edge
    logic active;  // a token is in the chain (output phase)
    logic last;    // token sits in the final stage
  } seqStrobe_t;
endpackage

// File: rtl/pixSeqCtrl.sv
module pixSeqCtrl
  import pixSeqPkg::*;
#(
  parameter int NUM_PIX = 128
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               startIn,
  output logic [NUM_PIX-1:0] tokenVec,
  output seqStrobe_t         strobe
);

  logic [NUM_PIX-1:0] chain;
  logic               busy;

  assign busy = |chain;

  always_comb begin
    strobe.take   = startIn && !busy;
    strobe.active = busy;
    strobe.last   = chain[NUM_PIX-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain <= '0;
    end else if (strobe.take) begin
      chain <= NUM_PIX'(1);
    end else begin
      chain <= chain << 1;
    end
  end

  assign tokenVec = chain;

  // R3
  token_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(chain));

  // R2
  start_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (startIn && !busy) |=> chain[0]);

  // R8
  start_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (startIn && busy) |=> !chain[0]);

  // R3
  token_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !chain[NUM_PIX-1]) |=> ($countones(chain) == 1));

endmodule

// File: rtl/pixSeqPath.sv
module pixSeqPath
  import pixSeqPkg::*;
#(
  parameter int NUM_PIX = 128,
  localparam int IDX_W = $clog2(NUM_PIX)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  seqStrobe_t         strobe,
  input  logic [NUM_PIX-1:0] tokenVec,
  output logic [NUM_PIX-1:0] pixSel,
  output logic [NUM_PIX-1:0] pixRst,
  output logic [IDX_W-1:0]   pixIdx,
  output logic               outEn,
  output logic               endScan
);

  logic [IDX_W-1:0]   idxReg;
  logic [NUM_PIX-1:0] rstReg;
  logic               eosReg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idxReg <= '0;
    end else if (strobe.take) begin
      idxReg <= '0;
    end else if (strobe.last) begin
      idxReg <= '0;
    end else if (strobe.active) begin
      idxReg <= idxReg + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rstReg <= '0;
      eosReg <= 1'b0;
    end else begin
      rstReg <= tokenVec;
      eosReg <= strobe.last;
    end
  end

  assign pixSel  = tokenVec;
  assign pixRst  = rstReg;
  assign pixIdx  = idxReg;
  assign outEn   = strobe.active;
  assign endScan = eosReg;

  // R6
  idx_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    outEn |-> pixSel[pixIdx]);

  // R4
  no_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pixRst & pixSel) == '0);

  // R7
  eos_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    endScan |=> !endScan);

  // R7
  eos_with_last_rst_chk: assert property (@(posedge clk) disable iff (!rst_n)
    endScan |-> pixRst[NUM_PIX-1]);

  // R4
  rst_follows_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pixSel[0] |=> pixRst[0]);

endmodule

// File: rtl/pixSeqTop.sv
module pixSeqTop
  import pixSeqPkg::*;
#(
  parameter int NUM_PIX = 128,
  localparam int IDX_W = $clog2(NUM_PIX)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               startIn,
  output logic [NUM_PIX-1:0] pixSel,
  output logic [NUM_PIX-1:0] pixRst,
  output logic [IDX_W-1:0]   pixIdx,
  output logic               outEn,
  output logic               endScan
);

  seqStrobe_t         strobe;
  logic [NUM_PIX-1:0] tokenVec;

  pixSeqCtrl #(.NUM_PIX(NUM_PIX)) ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .startIn  (startIn),
    .tokenVec (tokenVec),
    .strobe   (strobe)
  );

  pixSeqPath #(.NUM_PIX(NUM_PIX)) path (
    .clk      (clk),
    .rst_n    (rst_n),
    .strobe   (strobe),
    .tokenVec (tokenVec),
    .pixSel   (pixSel),
    .pixRst   (pixRst),
    .pixIdx   (pixIdx),
    .outEn    (outEn),
    .endScan  (endScan)
  );

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    !rst_n |-> (pixSel == '0 && pixRst == '0 && !endScan));

endmodule

// File: tb/pixSeqTop_test.sv
`timescale 1ns/1ps
module pixSeqTop_test;
  localparam int NP = 128;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          startIn = 1'b0;
  logic [NP-1:0] pixSel;
  logic [NP-1:0] pixRst;
  logic [6:0]    pixIdx;
  logic          outEn;
  logic          endScan;

  int  checks = 0;
  int  failures = 0;
  bit  loopback = 1'b0;
  bit  done = 1'b0;

  // behavioural reference
  int  tokPos = -1;   // selected pixel, -1 idle
  int  rstPos = -1;   // pixel being reset, -1 none
  bit  eosExp = 1'b0;
  int  scanCount = 0;

  always #2.5 clk = ~clk;

  pixSeqTop uut (
    .clk(clk), .rst_n(rst_n), .startIn(startIn),
    .pixSel(pixSel), .pixRst(pixRst), .pixIdx(pixIdx),
    .outEn(outEn), .endScan(endScan)
  );

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tokPos = -1; rstPos = -1; eosExp = 1'b0;
    end else begin
      int old;
      old = tokPos;
      eosExp = (old == NP-1);
      rstPos = old;
      if (old < 0 && startIn) begin
        tokPos = 0; scanCount++;
      end else if (old >= 0 && old < NP-1) tokPos = old + 1;
      else tokPos = -1;
    end
  end

  function automatic logic [NP-1:0] posVec(int p);
    logic [NP-1:0] v;
    v = '0;
    if (p >= 0) v[p] = 1'b1;
    return v;
  endfunction

  task automatic chk(bit ok, string req, string what, logic [NP-1:0] act, logic [NP-1:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic compareAll(string req);
    logic [NP-1:0] es, er;
    es = posVec(tokPos);
    er = posVec(rstPos);
    chk(pixSel === es, (req == "") ? "R3" : req, "pixSel", pixSel, es);
    chk(pixRst === er, "R4", "pixRst", pixRst, er);
    chk(outEn === (tokPos >= 0), "R5", "outEn", NP'(outEn), NP'(tokPos >= 0));
    chk(endScan === eosExp, "R7", "endScan", NP'(endScan), NP'(eosExp));
    if (tokPos >= 0)
      chk(pixIdx === 7'(tokPos), "R6", "pixIdx", NP'(pixIdx), NP'(tokPos));
  endtask

  // compare every cycle away from the edge, then drive new input
  task automatic step(bit s, string req = "");
    @(negedge clk);
    compareAll(req);
    startIn = loopback ? endScan : s;
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      failures++; checks++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int en;
    #1;
    // R1 during reset
    chk(pixSel === '0 && pixRst === '0 && outEn === 1'b0 && endScan === 1'b0,
        "R1", "in reset", pixSel | pixRst, '0);
    #10 rst_n = 1'b1;
    for (int i = 0; i < 4; i++) step(1'b0, "R1");

    // single pulse, full scan; count enable width
    step(1'b1, "R2");
    en = 0;
    for (int i = 0; i < 140; i++) begin
      step(1'b0);
      if (outEn) en++;
    end
    chk(en == NP, "R5", "outEn width", NP'(en), NP'(NP));

    // starts inside a scan: early, middle, and the last select cycle
    step(1'b1, "R2");
    for (int i = 0; i < 135; i++) begin
      step((i == 3 || i == 60 || i == 126 || i == 127) ? 1'b1 : 1'b0, "R8");
    end
    chk(scanCount == 2, "R8", "scans started", NP'(scanCount), NP'(2));

    // start held high: restarts right at the end-of-scan edge
    for (int i = 0; i < 300; i++) step(1'b1, "R9");
    for (int i = 0; i < 140; i++) step(1'b0, "R9");
    chk(scanCount == 5, "R9", "held-start scans", NP'(scanCount), NP'(5));

    // end-of-scan fed back to start
    step(1'b1, "R9");
    loopback = 1'b1;
    for (int i = 0; i < 3 * 129; i++) step(1'b0, "R9");
    loopback = 1'b0;
    for (int i = 0; i < 140; i++) step(1'b0, "R9");
    chk(scanCount == 9, "R9", "loopback scans", NP'(scanCount), NP'(9));

    // reset in the middle of a scan clears everything
    step(1'b1, "R2");
    for (int i = 0; i < 20; i++) step(1'b0);
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk(pixSel === '0 && pixRst === '0 && outEn === 1'b0 && endScan === 1'b0,
        "R1", "mid-scan reset", pixSel | pixRst, '0);
    #10 rst_n = 1'b1;
    for (int i = 0; i < 5; i++) step(1'b0, "R1");

    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule